// File: doc/BRIEF.md
# Genlockable Video Timing Generator

This block produces raster timing for a display. A horizontal counter steps once per clock and wraps at a programmed end count. A vertical counter steps at each line end and wraps at its own end count. Sync and blanking levels are decoded from the two counts. The block also raises a display-line interrupt, issues a refresh transfer request every programmed number of lines, and supports interlaced scanning. In interlaced mode it keeps a field-parity flag and shifts vertical sync by half a line in odd fields.

The block can follow an outside video source instead of running free. In external mode, each rising edge of a sampled external sync loads the matching counter with a programmed preset value. The preset lets the system absorb the delays between the source and this block. A single composite sync input can drive both counters:

- Its rising edges load the horizontal counter.
- A pulse that stays high longer than a programmed threshold is treated as vertical sync, which loads the vertical counter.
- The sync pulses recovered this way are presented as separate one-cycle outputs.

When running on its own timing in composite mode, the block merges its horizontal and vertical sync into one composite output. All sync signals are active high.

Top module: `vtg_genlock`

## Requirements
- R1: While rst_n is low, hcnt_o, vcnt_o and field_o are 0.
- R2: With ext_en low, hcnt_o counts up by one per clock and goes from h_end to 0. At that wrap, vcnt_o advances by one, or goes to 0 if it equals v_end. The ext_hs_i, ext_vs_i and ext_cs_i inputs have no effect on any output.
- R3: hsync_o is high when hcnt_o < h_sync_end. hblank_o is high when hcnt_o < h_blank_end or hcnt_o >= h_blank_start. vblank_o follows the same rule using vcnt_o, v_blank_end and v_blank_start.
- R4: With ext_en high and comp_en low, consider the clock edge at which ext_hs_i is sampled high after being sampled low. After that edge, hcnt_o equals h_preset. A rising ext_vs_i loads vcnt_o with v_preset in the same way. A load takes priority over the wrap.
- R5: With ext_en and comp_en high, a rising ext_cs_i loads hcnt_o with h_preset at that edge. sep_hs_o is high for the following cycle.
- R6: With ext_en and comp_en high, consider an ext_cs_i pulse that has already been sampled high on vs_thresh consecutive edges. At the next edge where it is still high, vcnt_o loads v_preset, and sep_vs_o is high for exactly one cycle. A pulse of vs_thresh samples or fewer has no vertical effect.
- R7: csync_o equals hsync_o OR vsync_o when comp_en is high and ext_en is low. Otherwise it is 0.
- R8: irq_o is high exactly when hcnt_o is 0 and vcnt_o equals int_line.
- R9: A line counter restarts at 0 on a frame wrap, on a vertical preset, and after xfer_lines lines. xfer_o is high when hcnt_o and this line counter are both 0.
- R10: With interlace high, field_o toggles at each frame wrap (h and v both at their end counts), unless a vertical preset occurs on that edge. With interlace low, field_o is 0 from the next edge on.
- R11: vsync_o is high when vcnt_o < v_sync_end, except in interlaced odd fields (field_o = 1). There, vsync_o spans from line 0 at count (h_end+1)/2 up to line v_sync_end at that same count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Follow external sync (1) or run free (0) |
| comp_en | input | 1 | Composite mode: split ext_cs_i, or merge own sync onto csync_o |
| interlace | input | 1 | Interlaced scanning |
| h_end | input | CW | Last horizontal count |
| h_sync_end | input | CW | First count after horizontal sync |
| h_blank_end | input | CW | First count after leading horizontal blank |
| h_blank_start | input | CW | First count of trailing horizontal blank |
| v_end | input | CW | Last line |
| v_sync_end | input | CW | First line after vertical sync |
| v_blank_end | input | CW | First line after leading vertical blank |
| v_blank_start | input | CW | First line of trailing vertical blank |
| h_preset | input | CW | Horizontal load value on external sync |
| v_preset | input | CW | Vertical load value on external sync |
| vs_thresh | input | TW | Composite high-time threshold for vertical sync |
| int_line | input | CW | Line that raises irq_o |
| xfer_lines | input | CW | Lines between transfer requests |
| ext_hs_i | input | 1 | External horizontal sync |
| ext_vs_i | input | 1 | External vertical sync |
| ext_cs_i | input | 1 | External composite sync |
| hcnt_o | output | CW | Horizontal count |
| vcnt_o | output | CW | Vertical count |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| csync_o | output | 1 | Merged composite sync |
| sep_hs_o | output | 1 | Horizontal pulse recovered from composite |
| sep_vs_o | output | 1 | Vertical pulse recovered from composite |
| field_o | output | 1 | Field parity |
| irq_o | output | 1 | Display-line interrupt request |
| xfer_o | output | 1 | Refresh transfer request |

## Verification
The bench builds the block with CW = 8 and TW = 4, which gives frames of a few hundred clocks. Many frame wraps, field toggles and transfer intervals therefore occur within a short run. The 4-bit threshold allows a threshold of 5, so composite pulses of exactly vs_thresh and vs_thresh + 1 samples are both applied directly. Random presets stay within the 8-bit range, and int_line is set to the last line, which places the interrupt on the wrap boundary.

// File: rtl/vtg_genlock.sv
module vtg_genlock #(
  parameter int CW = 12,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_en,
  input  logic          comp_en,
  input  logic          interlace,
  input  logic [CW-1:0] h_end,
  input  logic [CW-1:0] h_sync_end,
  input  logic [CW-1:0] h_blank_end,
  input  logic [CW-1:0] h_blank_start,
  input  logic [CW-1:0] v_end,
  input  logic [CW-1:0] v_sync_end,
  input  logic [CW-1:0] v_blank_end,
  input  logic [CW-1:0] v_blank_start,
  input  logic [CW-1:0] h_preset,
  input  logic [CW-1:0] v_preset,
  input  logic [TW-1:0] vs_thresh,
  input  logic [CW-1:0] int_line,
  input  logic [CW-1:0] xfer_lines,
  input  logic          ext_hs_i,
  input  logic          ext_vs_i,
  input  logic          ext_cs_i,
  output logic [CW-1:0] hcnt_o,
  output logic [CW-1:0] vcnt_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          csync_o,
  output logic          sep_hs_o,
  output logic          sep_vs_o,
  output logic          field_o,
  output logic          irq_o,
  output logic          xfer_o
);
  localparam int WW = TW + 1;

  logic [CW-1:0] hcnt, vcnt, lcnt;
  logic [WW-1:0] wcnt;
  logic [CW:0]   hhalf;
  logic field, hs_q, vs_q, cs_q, sep_hs_q, sep_vs_q;
  logic hs_rise, vs_rise, cs_rise, cs_det, h_ld, v_ld, hwrap, vwrap, odd;

  assign hs_rise = ext_hs_i & ~hs_q;
  assign vs_rise = ext_vs_i & ~vs_q;
  assign cs_rise = ext_cs_i & ~cs_q;
  assign cs_det  = ext_cs_i && (wcnt == {1'b0, vs_thresh});
  assign h_ld    = ext_en && (comp_en ? cs_rise : hs_rise);
  assign v_ld    = ext_en && (comp_en ? cs_det : vs_rise);
  assign hwrap   = (hcnt == h_end);
  assign vwrap   = hwrap && (vcnt == v_end);
  assign hhalf   = ({1'b0, h_end} + (CW+1)'(1)) >> 1;
  assign odd     = interlace & field;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0; vcnt <= '0; lcnt <= '0; wcnt <= '0;
      field <= 1'b0; hs_q <= 1'b0; vs_q <= 1'b0; cs_q <= 1'b0;
      sep_hs_q <= 1'b0; sep_vs_q <= 1'b0;
    end else begin
      hs_q <= ext_hs_i;
      vs_q <= ext_vs_i;
      cs_q <= ext_cs_i;
      if (!ext_cs_i)
        wcnt <= '0;
      else if (wcnt <= {1'b0, vs_thresh})
        wcnt <= wcnt + WW'(1);
      hcnt <= h_ld ? h_preset : (hwrap ? '0 : hcnt + CW'(1));
      if (v_ld)
        vcnt <= v_preset;
      else if (hwrap)
        vcnt <= vwrap ? '0 : vcnt + CW'(1);
      field <= interlace & (field ^ (vwrap & ~v_ld));
      if (v_ld)
        lcnt <= '0;
      else if (hwrap)
        lcnt <= (vwrap || lcnt == xfer_lines - CW'(1)) ? '0 : lcnt + CW'(1);
      sep_hs_q <= ext_en & comp_en & cs_rise;
      sep_vs_q <= ext_en & comp_en & cs_det;
    end
  end

  assign hcnt_o   = hcnt;
  assign vcnt_o   = vcnt;
  assign field_o  = field;
  assign sep_hs_o = sep_hs_q;
  assign sep_vs_o = sep_vs_q;
  assign hsync_o  = hcnt < h_sync_end;
  assign hblank_o = (hcnt < h_blank_end) || (hcnt >= h_blank_start);
  assign vblank_o = (vcnt < v_blank_end) || (vcnt >= v_blank_start);
  assign vsync_o  = !odd ? (vcnt < v_sync_end)
                  : (((vcnt == '0) ? ({1'b0, hcnt} >= hhalf) : (vcnt < v_sync_end))
                     || ((vcnt == v_sync_end) && ({1'b0, hcnt} < hhalf)));
  assign csync_o  = comp_en && !ext_en && (hsync_o || vsync_o);
  assign irq_o    = (hcnt == '0) && (vcnt == int_line);
  assign xfer_o   = (hcnt == '0) && (lcnt == '0);
endmodule

// File: rtl/vtg_genlock_chk.sv
module vtg_genlock_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_en,
  input logic          comp_en,
  input logic          interlace,
  input logic          ext_hs_i,
  input logic [CW-1:0] h_end,
  input logic [CW-1:0] h_preset,
  input logic [CW-1:0] hcnt_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          csync_o,
  input logic          sep_vs_o,
  input logic          field_o,
  input logic          irq_o
);
  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && hcnt_o == h_end) |=> (hcnt_o == '0)); // R2

  AST_H_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ext_en && !comp_en && ext_hs_i && !$past(ext_hs_i))
      |=> (hcnt_o == $past(h_preset))); // R4

  AST_SEP_VS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sep_vs_o |=> !sep_vs_o); // R6

  AST_CSYNC_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_en && !ext_en && (hsync_o || vsync_o)) |-> csync_o); // R7

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !ext_en && h_end != '0) |=> !irq_o); // R8

  AST_FIELD_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    !interlace |=> !field_o); // R10
endmodule

bind vtg_genlock vtg_genlock_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .comp_en(comp_en),
  .interlace(interlace), .ext_hs_i(ext_hs_i), .h_end(h_end),
  .h_preset(h_preset), .hcnt_o(hcnt_o), .hsync_o(hsync_o),
  .vsync_o(vsync_o), .csync_o(csync_o), .sep_vs_o(sep_vs_o),
  .field_o(field_o), .irq_o(irq_o)
);

// File: tb/vtg_genlock_tb.sv
`timescale 1ns/1ps
module vtg_genlock_tb_top;
  localparam int CW = 8;
  localparam int TW = 4;
  localparam int MSK = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ext_en, comp_en, interlace;
  logic [CW-1:0] h_end, h_sync_end, h_blank_end, h_blank_start;
  logic [CW-1:0] v_end, v_sync_end, v_blank_end, v_blank_start;
  logic [CW-1:0] h_preset, v_preset, int_line, xfer_lines;
  logic [TW-1:0] vs_thresh;
  logic ext_hs_i, ext_vs_i, ext_cs_i;
  logic [CW-1:0] hcnt_o, vcnt_o;
  logic hsync_o, vsync_o, hblank_o, vblank_o, csync_o;
  logic sep_hs_o, sep_vs_o, field_o, irq_o, xfer_o;

  vtg_genlock #(.CW(CW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .comp_en(comp_en),
    .interlace(interlace), .h_end(h_end), .h_sync_end(h_sync_end),
    .h_blank_end(h_blank_end), .h_blank_start(h_blank_start),
    .v_end(v_end), .v_sync_end(v_sync_end), .v_blank_end(v_blank_end),
    .v_blank_start(v_blank_start), .h_preset(h_preset), .v_preset(v_preset),
    .vs_thresh(vs_thresh), .int_line(int_line), .xfer_lines(xfer_lines),
    .ext_hs_i(ext_hs_i), .ext_vs_i(ext_vs_i), .ext_cs_i(ext_cs_i),
    .hcnt_o(hcnt_o), .vcnt_o(vcnt_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .hblank_o(hblank_o), .vblank_o(vblank_o), .csync_o(csync_o),
    .sep_hs_o(sep_hs_o), .sep_vs_o(sep_vs_o), .field_o(field_o),
    .irq_o(irq_o), .xfer_o(xfer_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, svs_seen = 0;
  int m_h, m_v, m_f, m_l, m_hq, m_vq, m_cq, m_w, m_shs, m_svs;
  int hr, vr, cr, cd, hld, vld, hw, vw;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  // reference model, stepped at each rising edge from the requirements
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
      finish_run();
    end
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_f = 0; m_l = 0; m_hq = 0; m_vq = 0; m_cq = 0;
      m_w = 0; m_shs = 0; m_svs = 0;
    end else begin
      hr  = int'(ext_hs_i) & (m_hq ^ 1);
      vr  = int'(ext_vs_i) & (m_vq ^ 1);
      cr  = int'(ext_cs_i) & (m_cq ^ 1);
      cd  = int'(ext_cs_i && m_w == int'(vs_thresh));
      hld = int'(ext_en) & (comp_en ? cr : hr);
      vld = int'(ext_en) & (comp_en ? cd : vr);
      hw  = int'(m_h == int'(h_end));
      vw  = hw & int'(m_v == int'(v_end));
      m_shs = int'(ext_en & comp_en) & cr;
      m_svs = int'(ext_en & comp_en) & cd;
      m_hq = int'(ext_hs_i); m_vq = int'(ext_vs_i); m_cq = int'(ext_cs_i);
      if (!ext_cs_i) m_w = 0;
      else if (m_w <= int'(vs_thresh)) m_w = m_w + 1;
      m_f = interlace ? (m_f ^ (vw & (vld ^ 1))) : 0;
      if (vld) m_l = 0;
      else if (hw) m_l = (vw || m_l == ((int'(xfer_lines) - 1) & MSK)) ? 0 : m_l + 1;
      if (vld) m_v = int'(v_preset);
      else if (hw) m_v = vw ? 0 : m_v + 1;
      m_h = hld ? int'(h_preset) : (hw ? 0 : (m_h + 1) & MSK);
    end
  end

  function automatic int e_vs();
    int hh = (int'(h_end) + 1) >> 1;
    if (!(interlace && m_f)) return int'(m_v < int'(v_sync_end));
    return int'(((m_v == 0) ? (m_h >= hh) : (m_v < int'(v_sync_end)))
                || (m_v == int'(v_sync_end) && m_h < hh));
  endfunction

  task automatic step();
    int ehs;
    @(negedge clk);
    ehs = int'(m_h < int'(h_sync_end));
    chk("R2/R4 hcnt", int'(hcnt_o), m_h);
    chk("R2/R4 vcnt", int'(vcnt_o), m_v);
    chk("R3 hsync", int'(hsync_o), ehs);
    chk("R3 hblank", int'(hblank_o), int'(m_h < int'(h_blank_end) || m_h >= int'(h_blank_start)));
    chk("R3 vblank", int'(vblank_o), int'(m_v < int'(v_blank_end) || m_v >= int'(v_blank_start)));
    chk("R11 vsync", int'(vsync_o), e_vs());
    chk("R7 csync", int'(csync_o), (comp_en && !ext_en) ? (ehs | e_vs()) : 0);
    chk("R5 sep_hs", int'(sep_hs_o), m_shs);
    chk("R6 sep_vs", int'(sep_vs_o), m_svs);
    chk("R10 field", int'(field_o), m_f);
    chk("R8 irq", int'(irq_o), int'(m_h == 0 && m_v == int'(int_line)));
    chk("R9 xfer", int'(xfer_o), int'(m_h == 0 && m_l == 0));
    if (sep_vs_o) svs_seen++;
  endtask

  task automatic cs_pulse(int gap, int width);
    repeat (gap) begin step(); ext_cs_i = 1'b0; end
    repeat (width) begin step(); ext_cs_i = 1'b1; end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ext_en = 1'b0; comp_en = 1'b0; interlace = 1'b0;
    h_end = 8'd23; h_sync_end = 8'd3; h_blank_end = 8'd5; h_blank_start = 8'd20;
    v_end = 8'd11; v_sync_end = 8'd2; v_blank_end = 8'd4; v_blank_start = 8'd10;
    h_preset = 8'd7; v_preset = 8'd3; vs_thresh = 4'd5;
    int_line = 8'd6; xfer_lines = 8'd3;
    ext_hs_i = 1'b1; ext_vs_i = 1'b1; ext_cs_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset hcnt", int'(hcnt_o), 0);
    chk("R1 reset vcnt", int'(vcnt_o), 0);
    chk("R1 reset field", int'(field_o), 0);
    ext_hs_i = 1'b0; ext_vs_i = 1'b0; ext_cs_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R2: free running, external inputs toggled randomly and ignored
    repeat (700) begin
      step();
      ext_hs_i = 1'($urandom); ext_vs_i = 1'($urandom); ext_cs_i = 1'($urandom);
    end

    // R10/R11: interlace, interrupt on last line (R8), transfer every line (R9)
    interlace = 1'b1; int_line = v_end; xfer_lines = 8'd1;
    repeat (900) begin
      step();
      ext_hs_i = 1'($urandom); ext_vs_i = 1'($urandom); ext_cs_i = 1'($urandom);
    end

    // R4: separate external syncs with random presets
    interlace = 1'b0; ext_en = 1'b1; xfer_lines = 8'd4; int_line = 8'd2;
    ext_cs_i = 1'b0;
    for (int k = 0; k < 1500; k++) begin
      step();
      ext_hs_i = (($urandom % 20) == 0);
      ext_vs_i = (($urandom % 150) == 0);
      if (k % 300 == 0) begin
        h_preset = 8'($urandom % 24);
        v_preset = 8'($urandom % 12);
      end
    end

    // R5/R6: composite input, mix of short and long pulses
    ext_hs_i = 1'b0; ext_vs_i = 1'b0; comp_en = 1'b1; interlace = 1'b1;
    for (int k = 0; k < 80; k++)
      cs_pulse(3 + int'($urandom % 20),
               (($urandom % 4) == 0) ? 4 + int'($urandom % 6) : 1 + int'($urandom % 3));

    // R6 boundary: width equal to threshold gives no vertical pulse
    cs_pulse(10, 0);
    svs_seen = 0;
    cs_pulse(0, 5);
    cs_pulse(6, 0);
    chk("R6 width=thresh no vertical", svs_seen, 0);
    // R6 boundary: one more sample gives exactly one vertical pulse
    svs_seen = 0;
    cs_pulse(0, 6);
    cs_pulse(6, 0);
    chk("R6 width=thresh+1 one vertical", svs_seen, 1);
    svs_seen = 0;
    cs_pulse(0, 14);
    cs_pulse(6, 0);
    chk("R6 long pulse one vertical", svs_seen, 1);

    // R7: generate composite from own sync
    ext_en = 1'b0; ext_cs_i = 1'b0;
    repeat (700) begin
      step();
      ext_cs_i = 1'($urandom);
    end

    // R10: leaving interlace clears parity
    interlace = 1'b0;
    step();
    step();
    chk("R10 field cleared", int'(field_o), 0);
    finish_run();
  end
endmodule